// File: doc/BRIEF.md
# JTAG User-Register Access Bridge

This block lets a host reach a small register file inside an FPGA through a user instruction of the test access port. The TAP controller is outside the block. It hands the bridge its capture, shift and update strobes and a select line that is high while the 6-bit user instruction is loaded. The bridge keeps a 38-bit shift register clocked by TCK, receives frames least-significant bit first, checks them, and passes each valid frame to the core clock domain through a toggle handshake.

Write frames load the job registers: eight 32-bit midstate words, three 32-bit message-tail words and a frequency setting. A read-request frame picks a register. The bridge latches the chosen word, and the next data scan shifts it out. Reading the result address pops one entry from a 16-deep FIFO, which the hashing core fills through a valid/data port. An empty FIFO reads as all ones. The FIFO depth must be a power of two.

Top module: `jtag_regbridge`

## Requirements
- R1: A 38-bit write frame (bits 31:0 data, bits 35:32 address, bit 36 = 1, bit 37 parity) with an odd number of ones writes the data to the addressed register. Addresses 1..8 appear as midstate words 0..7 and addresses 9..11 as tail words 0..2.
- R2: A 6-bit read request (bits 3:0 address, bit 4 = 0, bit 5 parity, odd ones overall) latches the addressed word. The next data scan returns it on `tdo`, bit 0 first, one bit per shift.
- R3: A frame whose ones count is even is discarded, and every register is left unchanged.
- R4: A scan whose shift count is neither 38 nor 6 is discarded. A 38-bit frame with bit 36 = 0 and a 6-bit frame with bit 4 = 1 are also discarded.
- R5: While `ir_sel` is low, capture, shift and update strobes have no effect.
- R6: Address 13 holds the target frequency in MHz on `freq_mhz`. `clk_mult` is that value divided by two.
- R7: A read request for address 14 pops the oldest FIFO entry in push order. If the FIFO is empty, the read returns 0xFFFFFFFF.
- R8: Further data scans with no new read request return the same latched word and pop nothing more.
- R9: The FIFO holds 16 entries. A push while it is full is dropped and increments `ovf_cnt`.
- R10: Addresses 0, 12 and 15 read as zero and ignore writes. A write to address 14 is ignored.
- R11: After reset, all registers and `ovf_cnt` are zero, the FIFO is empty and `tdo` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tck | input | 1 | Test clock |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the shift register |
| ir_sel | input | 1 | User instruction is loaded |
| capture | input | 1 | TAP in Capture-DR |
| shift | input | 1 | TAP in Shift-DR |
| update | input | 1 | TAP in Update-DR |
| res_valid | input | 1 | Push strobe from the hashing core |
| res_data | input | 32 | Result word to push |
| midstate | output | 256 | Registers 1..8, word 0 in bits 31:0 |
| tail | output | 96 | Registers 9..11, word 0 in bits 31:0 |
| freq_mhz | output | 32 | Register 13 |
| clk_mult | output | 31 | Clock multiplier, `freq_mhz` divided by two |
| ovf_cnt | output | OVF_W | Number of dropped pushes |

## Verification
The assertions check on every core cycle the FIFO occupancy bound, the overflow counter (it steps on each push into a full FIFO and holds otherwise), the all-ones read of an empty FIFO, and the rule that register outputs move only when a synchronised frame arrives. Only the bench scenarios can show the serial behaviour: bit order and field positions of frames, rejection of bad parity, wrong lengths and flipped direction flags, the effect of the instruction select, the repeatability of a data scan, and FIFO ordering around overflow.

// File: rtl/jtag_regbridge.sv
module jtag_regbridge #(
  parameter int DEPTH = 16,
  parameter int OVF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tck,
  input  logic             tdi,
  output logic             tdo,
  input  logic             ir_sel,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             res_valid,
  input  logic [31:0]      res_data,
  output logic [255:0]     midstate,
  output logic [95:0]      tail,
  output logic [31:0]      freq_mhz,
  output logic [30:0]      clk_mult,
  output logic [OVF_W-1:0] ovf_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);
  localparam logic [3:0] A_RES = 4'hE;
  localparam logic [3:0] A_FRQ = 4'hD;

  // TCK domain
  logic [37:0] sr;
  logic [5:0]  nbits;
  logic [31:0] fr_data;
  logic [3:0]  fr_addr;
  logic        fr_wr, req_tgl;
  logic [31:0] rd_hold;

  wire wr_ok = (nbits == 6'd38) && sr[36] && (^sr);
  wire rd_ok = (nbits == 6'd6) && !sr[36] && (^sr[37:32]);
  assign tdo = sr[0];

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) begin
      sr <= '0; nbits <= '0; fr_data <= '0; fr_addr <= '0;
      fr_wr <= 1'b0; req_tgl <= 1'b0;
    end else if (ir_sel) begin
      if (capture) begin
        sr <= {6'b0, rd_hold};
        nbits <= '0;
      end else if (shift) begin
        sr <= {tdi, sr[37:1]};
        if (nbits != 6'd63) nbits <= nbits + 6'd1;
      end else if (update && (wr_ok || rd_ok)) begin
        fr_data <= sr[31:0];
        fr_addr <= sr[35:32];
        fr_wr   <= wr_ok;
        req_tgl <= ~req_tgl;
      end
    end

  // core domain
  logic [2:0] rq_sync;
  wire evt = rq_sync[2] ^ rq_sync[1];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rq_sync <= '0;
    else        rq_sync <= {rq_sync[1:0], req_tgl};

  logic [31:0] regs [16];
  logic [31:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] fcnt;

  wire wr_en  = evt && fr_wr &&
                (((fr_addr >= 4'd1) && (fr_addr <= 4'd11)) || fr_addr == A_FRQ);
  wire rd_res = evt && !fr_wr && (fr_addr == A_RES);
  wire pop    = rd_res && (fcnt != '0);
  wire full   = (fcnt == CAP);
  wire push   = res_valid && !full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= '0;
      rd_hold <= '0;
    end else if (evt) begin
      if (wr_en)       regs[fr_addr] <= fr_data;
      else if (rd_res) rd_hold <= pop ? mem[rp] : 32'hFFFF_FFFF;
      else if (!fr_wr) rd_hold <= regs[fr_addr];
    end

  always_ff @(posedge clk)
    if (push) mem[wp] <= res_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0; ovf_cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      fcnt <= fcnt + (AW+1)'(push) - (AW+1)'(pop);
      if (res_valid && full) ovf_cnt <= ovf_cnt + 1'b1;
    end

  always_comb begin
    for (int i = 0; i < 8; i++) midstate[32*i +: 32] = regs[i+1];
    for (int i = 0; i < 3; i++) tail[32*i +: 32] = regs[i+9];
  end
  assign freq_mhz = regs[13];
  assign clk_mult = regs[13][31:1];

  a_r9_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= CAP);
  a_r9_overflow_step: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && full) |=> ovf_cnt == $past(ovf_cnt) + {{(OVF_W-1){1'b0}}, 1'b1});
  a_r9_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(ovf_cnt));
  a_r7_empty_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && fcnt == '0) |=> rd_hold == 32'hFFFF_FFFF);
  a_r3_regs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(midstate) && $stable(tail) && $stable(freq_mhz));
endmodule

// File: tb/jtag_regbridge_test.sv
module jtag_regbridge_test;
  logic clk = 0, rst_n = 0, tck = 0, tdi = 0, ir_sel = 1;
  logic capture = 0, shift = 0, update = 0, res_valid = 0;
  logic [31:0] res_data = 0;
  wire tdo;
  wire [255:0] midstate;
  wire [95:0] tail;
  wire [31:0] freq_mhz;
  wire [30:0] clk_mult;
  wire [15:0] ovf_cnt;

  jtag_regbridge uut (.clk(clk), .rst_n(rst_n), .tck(tck), .tdi(tdi), .tdo(tdo),
    .ir_sel(ir_sel), .capture(capture), .shift(shift), .update(update),
    .res_valid(res_valid), .res_data(res_data), .midstate(midstate), .tail(tail),
    .freq_mhz(freq_mhz), .clk_mult(clk_mult), .ovf_cnt(ovf_cnt));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mdl [16];
  logic [31:0] fq [$];
  int ovf_exp = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit writable(logic [3:0] a);
    return (a >= 4'd1 && a <= 4'd11) || a == 4'd13;
  endfunction
  function automatic logic [63:0] wframe(logic [3:0] a, logic [31:0] d, bit flag);
    logic [36:0] b = {flag, a, d};
    return {26'b0, ~^b, b};
  endfunction
  function automatic logic [63:0] rframe(logic [3:0] a, bit flag);
    logic [4:0] b = {flag, a};
    return {58'b0, ~^b, b};
  endfunction

  task automatic pulse();
    #100 tck = 1; #100 tck = 0;
  endtask
  task automatic scan(logic [63:0] bits, int n);
    capture = 1; pulse(); capture = 0;
    for (int i = 0; i < n; i++) begin tdi = bits[i]; shift = 1; pulse(); end
    shift = 0; tdi = 0;
    update = 1; pulse(); update = 0;
    repeat (6) @(negedge clk);
  endtask
  task automatic data_scan(output logic [31:0] v);
    capture = 1; pulse(); capture = 0;
    for (int i = 0; i < 32; i++) begin v[i] = tdo; shift = 1; pulse(); end
    shift = 0;
    update = 1; pulse(); update = 0;
    repeat (6) @(negedge clk);
  endtask
  task automatic do_write(logic [3:0] a, logic [31:0] d);
    scan(wframe(a, d, 1'b1), 38);
    if (writable(a)) mdl[a] = d;
  endtask
  task automatic do_read(logic [3:0] a, output logic [31:0] v);
    scan(rframe(a, 1'b0), 6);
    data_scan(v);
  endtask
  task automatic push(logic [31:0] d);
    @(negedge clk) res_valid = 1; res_data = d;
    @(negedge clk) res_valid = 0;
    if (fq.size() < 16) fq.push_back(d); else ovf_exp++;
  endtask
  function automatic logic [31:0] pop_exp();
    if (fq.size() == 0) return 32'hFFFF_FFFF;
    return fq.pop_front();
  endfunction
  task automatic check_outputs(string req);
    for (int i = 0; i < 8; i++) check(req, midstate[32*i +: 32], mdl[i+1]);
    for (int i = 0; i < 3; i++) check(req, tail[32*i +: 32], mdl[i+9]);
    check(req, freq_mhz, mdl[13]);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w;
    logic [3:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R11 reset state
    check("R11 tdo", {31'b0, tdo}, 32'd0);
    check("R11 ovf", {16'b0, ovf_cnt}, 32'd0);
    check_outputs("R11");
    do_read(4'hE, v); check("R11 fifo empty", v, 32'hFFFF_FFFF);

    // R1 R2 R10 constrained random writes and readbacks
    for (int k = 0; k < 30; k++) begin
      a = 4'($urandom_range(0, 15));
      if (a == 4'hE) a = 4'h5;
      do_write(a, $urandom);
      a = 4'($urandom_range(0, 15));
      if (a == 4'hE) a = 4'h1;
      do_read(a, v);
      check(writable(a) ? "R2 readback" : "R10 unmapped reads zero", v, writable(a) ? mdl[a] : 32'd0);
    end
    check_outputs("R1");

    // R10 write to result address ignored, unmapped stays zero
    do_write(4'hE, 32'h1234_5678);
    do_read(4'hE, v); check("R10 write to 14 ignored", v, 32'hFFFF_FFFF);
    do_write(4'hC, 32'hDEAD_BEEF);
    do_read(4'hC, v); check("R10 addr 12 zero", v, 32'd0);

    // R6 frequency register
    do_write(4'hD, 32'd200);
    check("R6 freq", freq_mhz, 32'd200);
    check("R6 mult", {1'b0, clk_mult}, 32'd100);
    do_write(4'hD, 32'd251);
    check("R6 mult odd", {1'b0, clk_mult}, 32'd125);

    // R3 bad parity dropped
    do_write(4'h5, 32'hA5A5_0001);
    scan(wframe(4'h5, 32'h0BAD_0BAD, 1'b1) ^ (64'd1 << 37), 38);
    do_read(4'h5, v); check("R3 bad parity", v, 32'hA5A5_0001);
    check_outputs("R3");

    // R4 wrong lengths and flags
    scan(wframe(4'h5, 32'h1111_2222, 1'b1), 37);
    do_read(4'h5, v); check("R4 len37", v, 32'hA5A5_0001);
    scan(wframe(4'h5, 32'h3333_4444, 1'b1) | (64'd1 << 38), 39);
    do_read(4'h5, v); check("R4 len39", v, 32'hA5A5_0001);
    scan(wframe(4'h5, 32'h5555_6666, 1'b0), 38);
    do_read(4'h5, v); check("R4 write flag clear", v, 32'hA5A5_0001);
    do_read(4'h1, w);
    scan(rframe(4'h5, 1'b1), 6);
    data_scan(v); check("R4 read flag set", v, w);

    // R5 instruction not selected
    ir_sel = 0;
    scan(wframe(4'h5, 32'h7777_8888, 1'b1), 38);
    ir_sel = 1;
    do_read(4'h5, v); check("R5 deselected write", v, 32'hA5A5_0001);
    ir_sel = 0;
    scan(rframe(4'h9, 1'b0), 6);
    ir_sel = 1;
    data_scan(v); check("R5 deselected read", v, 32'hA5A5_0001);

    // R7 R8 FIFO ordering and repeat scans
    push(32'hC0DE_0001); push(32'hC0DE_0002); push(32'hC0DE_0003);
    do_read(4'hE, v); check("R7 pop order", v, pop_exp());
    data_scan(w); check("R8 repeat scan", w, v);
    push(32'hC0DE_0004);
    for (int k = 0; k < 4; k++) begin
      do_read(4'hE, v); check("R7 pop", v, pop_exp());
    end

    // R9 overflow
    for (int k = 0; k < 20; k++) push($urandom);
    check("R9 overflow count", {16'b0, ovf_cnt}, 32'(ovf_exp));
    for (int k = 0; k < 17; k++) begin
      do_read(4'hE, v); check("R9 R7 drain", v, pop_exp());
    end
    check("R9 overflow held", {16'b0, ovf_cnt}, 32'(ovf_exp));
    check_outputs("R1 final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule